// File: doc/BRIEF.md
# Latched Interrupt Controller with Read-to-Disable Enable

This block gathers the interrupt lines of an I/O processor's peripherals into one request line for the processor core. Each line is watched for a rising edge. An edge latches a pending bit in a status register. A per-line mask register selects which pending bits may reach the core. A single global enable bit gates the combined request.

Software uses a small register bus with three word registers. Pending bits are acknowledged by writing 0 to them. A 1 in the write data leaves that bit alone, so one line can be cleared without disturbing the others.

The enable register has a read side effect. Reading it returns the enable as it was and turns interrupts off in the same access. A critical section can therefore save and disable the enable in one bus operation, and restore it later with a plain write.

Top module: `irq_hub_top`

## Requirements
- R1: After reset, the status, mask and enable registers read 0 and `irq_out` is 0.
- R2: A rising edge on `src[i]` sets status bit i. A line that stays high sets its bit only once, so after an acknowledge the bit stays 0 until the line falls and rises again.
- R3: A write to the status register (byte offset 0x0) clears each status bit whose write-data bit is 0 and keeps each bit whose write-data bit is 1. Status bits 31..26 always read 0.
- R4: If a source edge and a status write that clears the same bit fall in one cycle, the bit ends up set.
- R5: The mask register (byte offset 0x4) holds the value written to bits 25..0, where 1 enables a line. Bits 31..26 read 0. The mask keeps its value when it is not written.
- R6: A write to the enable register (byte offset 0x8) loads write-data bit 0 into the enable, so it can set or clear it. Enable-register bits 31..1 read 0.
- R7: A read of the enable register returns the enable value from before the read. The enable is 0 from the next cycle on, unless the same cycle also writes it.
- R8: `irq_out` is registered. It equals, one clock later, the enable AND the OR of (status AND mask).
- R9: Byte offset 0xC reads 0. A write to 0xC changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src | input | NUM_SRC (26) | Interrupt source lines |
| bus_addr | input | ADDR_W (4) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high, 0 otherwise |
| irq_out | output | 1 | Interrupt request to the core |

## Verification
Read data is combinational, so the bench compares it in the same cycle as the read strobe. A source edge that is present before clock edge E shows up in a status read in the cycle after E. A write or a read side effect at edge E is visible to reads from the next cycle on. `irq_out` follows any register change one edge later, so the bench checks it at the falling edge after the next rising edge. Every read pushes its expected word into a queue, and a monitor pops and compares that word at the falling edge of the read cycle.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int REG_W = 32;

  // Word select taken from byte-address bits [3:2].
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e word_sel(input logic [1:0] widx);
    return reg_sel_e'(widx);
  endfunction

  // Acknowledge: a 0 in keep clears, a 1 keeps; new edges always win.
  function automatic logic [REG_W-1:0] ack_apply(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] keep,
                                                 input logic [REG_W-1:0] set);
    return (cur & keep) | set;
  endfunction

  function automatic logic req_eval(input logic en,
                                    input logic [REG_W-1:0] stat,
                                    input logic [REG_W-1:0] mask);
    return en & (|(stat & mask));
  endfunction
endpackage

// File: rtl/irq_hub_edge.sv
module irq_hub_edge #(
  parameter int N = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  output logic [N-1:0] rise
);
  logic [N-1:0] src_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q[i] <= 1'b0;
      else        src_q[i] <= src[i];
    end
    assign rise[i] = src[i] & ~src_q[i];
  end

  // R2: an edge only lasts one cycle while the line stays high
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int N = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     rise,
  input  reg_sel_e         sel,
  input  logic             wr,
  input  logic             rd,
  input  logic [REG_W-1:0] wdata,
  output logic [N-1:0]     stat,
  output logic [N-1:0]     mask,
  output logic             gen_en,
  output logic [REG_W-1:0] rdata
);
  logic wr_stat, wr_mask, wr_ctrl, rd_ctrl;
  logic [REG_W-1:0] stat_w, mask_w, set_w, stat_nx;

  assign wr_stat = wr && (sel == SEL_STAT);
  assign wr_mask = wr && (sel == SEL_MASK);
  assign wr_ctrl = wr && (sel == SEL_CTRL);
  assign rd_ctrl = rd && (sel == SEL_CTRL);

  assign stat_w = REG_W'(stat);
  assign mask_w = REG_W'(mask);
  assign set_w  = REG_W'(rise);

  always_comb begin
    if (wr_stat) stat_nx = ack_apply(stat_w, wdata, set_w);
    else         stat_nx = stat_w | set_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat   <= '0;
      mask   <= '0;
      gen_en <= 1'b0;
    end else begin
      stat <= stat_nx[N-1:0];
      if (wr_mask) mask <= wdata[N-1:0];
      if (wr_ctrl)      gen_en <= wdata[0];
      else if (rd_ctrl) gen_en <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (sel)
        SEL_STAT: rdata = stat_w;
        SEL_MASK: rdata = mask_w;
        SEL_CTRL: rdata = REG_W'(gen_en);
        default:  rdata = '0;
      endcase
    end
  end

  // R2: every edge leaves its status bit set
  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((stat & $past(rise)) == $past(rise)));
  // R3: an acknowledge without new edges leaves only the kept bits
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && rise == '0) |=> (stat == ($past(stat) & $past(wdata[N-1:0]))));
  // R4: an edge that coincides with an acknowledge write survives
  p_set_beats_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && rise != '0) |=> ((stat & $past(rise)) == $past(rise)));
  // R5: the mask holds when it is not written
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask));
  // R7: a read of the enable register disables interrupts
  p_rd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !wr_ctrl) |=> !gen_en);
  // R9: the unmapped word never returns data
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (rdata == '0));
endmodule

// File: rtl/irq_hub_req.sv
module irq_hub_req
  import irq_hub_pkg::*;
#(
  parameter int N = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] mask,
  input  logic         gen_en,
  output logic         irq_q
);
  logic req_now;

  assign req_now = req_eval(gen_en, REG_W'(stat), REG_W'(mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= req_now;
  end

  // R8: the request is off while the enable was off a cycle earlier
  p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !irq_q);
  // R8: the request follows pending-and-enabled lines by one cycle
  p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && (stat & mask) != '0) |=> irq_q);
endmodule

// File: rtl/irq_hub_top.sv
module irq_hub_top
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 26,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] rise_evt;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] mask_q;
  logic               gen_en;
  reg_sel_e           sel;

  assign sel = word_sel(bus_addr[3:2]);

  irq_hub_edge #(.N(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src(src), .rise(rise_evt)
  );

  irq_hub_regs #(.N(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .rise(rise_evt), .sel(sel),
    .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata),
    .stat(stat_q), .mask(mask_q), .gen_en(gen_en), .rdata(bus_rdata)
  );

  irq_hub_req #(.N(NUM_SRC)) u_req (
    .clk(clk), .rst_n(rst_n), .stat(stat_q), .mask(mask_q),
    .gen_en(gen_en), .irq_q(irq_out)
  );

  // R1: nothing is requested in the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq_out);
endmodule

// File: tb/irq_hub_top_bench.sv
module irq_hub_top_bench;
  localparam int NS = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  irq_hub_top u_irq_hub_top (
    .clk(clk), .rst_n(rst_n), .src(src), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // Monitor: compare each read against the queued expectation.
  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(posedge clk); #1; src[i] = 1'b1;
    @(posedge clk); #1; src[i] = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(posedge clk); @(negedge clk);
    total++;
    if (irq_out !== e) begin
      bad++;
      $display("FAIL %s: irq_out got %b expected %b", t, irq_out, e);
    end
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog: run got hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset values
    chk_irq(1'b0, "R1 irq after reset");
    rd_reg(4'h0, 32'h0, "R1 status after reset");
    rd_reg(4'h4, 32'h0, "R1 mask after reset");
    rd_reg(4'h8, 32'h0, "R1 enable after reset");
    // R5: mask width
    wr_reg(4'h4, 32'hFFFF_FFFF);
    rd_reg(4'h4, 32'h03FF_FFFF, "R5 mask upper bits zero");
    // R2: edge latching
    pulse(3); pulse(7);
    rd_reg(4'h0, 32'h0000_0088, "R2 pulses latched");
    chk_irq(1'b0, "R8 no request while disabled");
    // R6 / R7 / R8: enable and read-to-disable
    wr_reg(4'h8, 32'hFFFF_FFFF);
    chk_irq(1'b1, "R8 request after enable");
    rd_reg(4'h8, 32'h1, "R6 R7 enable reads pre-clear value");
    rd_reg(4'h8, 32'h0, "R7 enable cleared by read");
    chk_irq(1'b0, "R8 request drops after read-disable");
    // R3: acknowledge by writing 0
    wr_reg(4'h0, ~32'h8);
    rd_reg(4'h0, 32'h0000_0080, "R3 only bit 3 cleared");
    // R2: held level sets once
    @(posedge clk); #1 src[5] = 1'b1;
    rd_reg(4'h0, 32'h0000_00A0, "R2 level sets bit 5");
    wr_reg(4'h0, 32'h0);
    rd_reg(4'h0, 32'h0, "R2 held line does not re-set");
    // R4: set wins over acknowledge
    @(posedge clk); #1;
    bus_addr = 4'h0; bus_wdata = 32'h0; bus_wr = 1'b1; src[9] = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; src[9] = 1'b0; src[5] = 1'b0;
    rd_reg(4'h0, 32'h0000_0200, "R4 edge survives acknowledge");
    // R8: mask gating
    wr_reg(4'h4, 32'h03FF_FDFF);
    wr_reg(4'h8, 32'h1);
    chk_irq(1'b0, "R8 masked line gives no request");
    wr_reg(4'h4, 32'h0000_0200);
    chk_irq(1'b1, "R8 unmasked line requests");
    // R9: unmapped word
    wr_reg(4'hC, 32'h0);
    rd_reg(4'hC, 32'h0, "R9 unmapped reads zero");
    rd_reg(4'h4, 32'h0000_0200, "R9 mask untouched by unmapped write");
    chk_irq(1'b1, "R9 enable untouched by unmapped write");
    // R6: write 0 clears enable
    wr_reg(4'h8, 32'hFFFF_FFFE);
    chk_irq(1'b0, "R6 enable written to 0");
    rd_reg(4'h8, 32'h0, "R6 enable reads 0 after write");
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule